// File: doc/BRIEF.md
# Time-aligned periodic pulse generator

This block produces periodic output pulses, for example one pulse per second, that stay locked to a free-running time counter kept elsewhere on the chip. The time counter advances by a nominal tick. A shared divider groups ticks into a slower output clock, and one output-clock period sets the pulse width. Each of several independent interval units holds a remaining-time register in nanoseconds. On every tick this register drops by the tick period. When it runs out, the unit raises its pulse line and reloads.

The interval units do not start freely. Software sets a start enable and a 64-bit alarm time, normally one tick period before a whole second. The units start together in the cycle the current time equals that alarm, so every pulse train lines up with the second boundary. To reprogram the prescale or interval values, software drops the enable, writes the new values, moves the alarm and raises the enable again. An interval value is written as prescale × tick period × division − tick period, in nanoseconds.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset every pulse line and every event strobe is low, and the generator stays idle until it is started.
- R2: The generator starts only while the start enable is high and the current time equals the alarm time. Ticks seen before the start are not counted, and no pulse appears without a match.
- R3: The start is one-shot. Once running, the generator ignores further cycles in which the time still equals the alarm, and counting continues without restarting.
- R4: Each interval unit loads its interval value V at start. On each tick it subtracts the tick period T while its remaining value is at least T. On the tick that finds the remaining value below T, it fires and reloads V. Pulses therefore come every (V+T)/T ticks, and the first one arrives that many ticks after the start.
- R5: The shared prescaler wraps every P ticks, counted from the start, where P is the prescale value. A pulse line goes high on its firing tick and goes low on the first later wrap tick that is not also a firing tick. A pulse whose firing tick falls on a wrap therefore lasts exactly P ticks.
- R6: A prescale value of 0 behaves as 1, so the prescaler wraps on every tick.
- R7: Event bit g (bit 0 belongs to unit 0, bit 1 to unit 1) is high for exactly the one clock cycle after the edge that samples unit g's firing tick. While an event bit is high, the matching pulse line is also high.
- R8: The interval units run independently, each with its own interval value, and share only the prescaler and the start.
- R9: Two cycles after the start enable goes low, all pulse lines and events are low. The generator then stays idle whatever ticks arrive, until the enable is high again and a new alarm match occurs.
- R10: While running, pulse lines change only on clock edges that sample a tick. Event bits are low in cycles that follow a non-tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Nominal tick strobe, one cycle per time-counter update |
| start_en_i | input | 1 | Enables alarm-triggered start; low stops all units |
| time_i | input | 64 | Current time in nanoseconds |
| alarm_i | input | 64 | Start alarm time in nanoseconds |
| tick_ns_i | input | 10 | Tick period in nanoseconds |
| prescale_i | input | 16 | Output-clock division factor in ticks |
| interval_i | input | 64 | Interval values, unit g in bits [32g+31:32g] |
| pulse_o | output | 2 | Pulse line per unit |
| event_o | output | 2 | One-cycle firing strobe per unit |

## Verification
The bench builds the block with its default parameters: two interval units, 32-bit interval values, a 10-bit tick period, a 16-bit prescaler and the registered alarm compare. It programs a 5 ns tick with prescale 4 and division factors 3 and 2. These small values bring the interleaved periods of 12 and 8 ticks, the coincident firing of both units at tick 24, and pulse edges that land on prescaler wraps within a few dozen ticks. A second setup with prescale 0 reaches one-tick pulses and back-to-back firing of the two units.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
   parameter int unsigned PTG_TIME_W  = 64;
   parameter int unsigned PTG_IVAL_W  = 32;
   parameter int unsigned PTG_PRSC_W  = 16;
   parameter int unsigned PTG_PER_W   = 10;
   parameter int unsigned PTG_NUM_GEN = 2;

   typedef enum logic {
      ARM_IDLE = 1'b0,
      ARM_RUN  = 1'b1
   } arm_state_e;
endpackage

// File: rtl/ptg_arm.sv
module ptg_arm
   import ptg_pkg::*;
#(
   parameter int unsigned TIME_W    = PTG_TIME_W,
   parameter bit          MATCH_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [TIME_W-1:0] time_i,
   input  logic [TIME_W-1:0] alarm_i,
   output logic              run_o
);
   arm_state_e state_q;
   logic       hit;
   logic       eq_now;

   assign eq_now = (time_i == alarm_i);

   // Either compare the wide values directly or cut the compare path with a register.
   generate
      if (MATCH_PIPE) begin : g_pipe
         logic eq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) eq_q <= 1'b0;
            else        eq_q <= eq_now;
         end
         assign hit = eq_q;
      end else begin : g_direct
         assign hit = eq_now;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                               state_q <= ARM_IDLE;
      else if (!en_i)                           state_q <= ARM_IDLE;
      else if (state_q == ARM_IDLE && hit)      state_q <= ARM_RUN;
   end

   assign run_o = (state_q == ARM_RUN);

   // R9: dropping the enable stops the generator on the next edge
   p_stop_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !run_o);

   // R2: a start never happens without the enable
   p_start_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> $past(en_i));
endmodule

// File: rtl/ptg_prescale.sv
module ptg_prescale
   import ptg_pkg::*;
#(
   parameter int unsigned PRSC_W = PTG_PRSC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic [PRSC_W-1:0] prescale_i,
   output logic              wrap_o
);
   logic [PRSC_W-1:0] cnt_q;
   logic [PRSC_W-1:0] last;

   // A factor of zero divides by one.
   assign last   = (prescale_i == '0) ? '0 : prescale_i - PRSC_W'(1);
   assign wrap_o = run_i && tick_i && (cnt_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!run_i)    cnt_q <= '0;
      else if (tick_i) begin
         if (wrap_o)      cnt_q <= '0;
         else             cnt_q <= cnt_q + PRSC_W'(1);
      end
   end
endmodule

// File: rtl/ptg_interval.sv
module ptg_interval
   import ptg_pkg::*;
#(
   parameter int unsigned IVAL_W = PTG_IVAL_W,
   parameter int unsigned PER_W  = PTG_PER_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic              wrap_i,
   input  logic [IVAL_W-1:0] ival_i,
   input  logic [PER_W-1:0]  tick_ns_i,
   output logic              pulse_o,
   output logic              evt_o
);
   logic [IVAL_W-1:0] remain_q;
   logic [IVAL_W-1:0] step;
   logic              expire;

   assign step   = IVAL_W'(tick_ns_i);
   assign expire = run_i && tick_i && (remain_q < step);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
         pulse_o  <= 1'b0;
         evt_o    <= 1'b0;
      end else if (!run_i) begin
         remain_q <= ival_i;
         pulse_o  <= 1'b0;
         evt_o    <= 1'b0;
      end else begin
         evt_o <= expire;
         if (tick_i) begin
            if (expire) begin
               remain_q <= ival_i;
               pulse_o  <= 1'b1;
            end else begin
               remain_q <= remain_q - step;
               if (wrap_i) pulse_o <= 1'b0;
            end
         end
      end
   end

   // R7: an event strobe only appears with its pulse line high
   p_evt_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> pulse_o);

   // R10: the pulse line holds across edges that carry no tick
   p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && $past(run_i) && !$past(tick_i)) |-> $stable(pulse_o));

   // R9: an idle unit clears its outputs
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!pulse_o && !evt_o));
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
   import ptg_pkg::*;
#(
   parameter int unsigned NUM_GEN    = PTG_NUM_GEN,
   parameter int unsigned TIME_W     = PTG_TIME_W,
   parameter int unsigned IVAL_W     = PTG_IVAL_W,
   parameter int unsigned PRSC_W     = PTG_PRSC_W,
   parameter int unsigned PER_W      = PTG_PER_W,
   parameter bit          MATCH_PIPE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_i,
   input  logic                      start_en_i,
   input  logic [TIME_W-1:0]         time_i,
   input  logic [TIME_W-1:0]         alarm_i,
   input  logic [PER_W-1:0]          tick_ns_i,
   input  logic [PRSC_W-1:0]         prescale_i,
   input  logic [NUM_GEN*IVAL_W-1:0] interval_i,
   output logic [NUM_GEN-1:0]        pulse_o,
   output logic [NUM_GEN-1:0]        event_o
);
   localparam int unsigned IVAL_BITS = NUM_GEN * IVAL_W;

   generate
      if (NUM_GEN < 1 || NUM_GEN > 16) begin : g_bad_num
         $error("pulse_train_gen: NUM_GEN out of range");
      end
      if (PER_W > IVAL_W) begin : g_bad_per
         $error("pulse_train_gen: tick period wider than interval");
      end
      if (PRSC_W < 1 || TIME_W < 1) begin : g_bad_w
         $error("pulse_train_gen: zero width");
      end
   endgenerate

   logic running;
   logic wrap;

   ptg_arm #(
      .TIME_W     (TIME_W),
      .MATCH_PIPE (MATCH_PIPE)
   ) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (start_en_i),
      .time_i  (time_i),
      .alarm_i (alarm_i),
      .run_o   (running)
   );

   ptg_prescale #(
      .PRSC_W (PRSC_W)
   ) u_prsc (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (running),
      .tick_i     (tick_i),
      .prescale_i (prescale_i),
      .wrap_o     (wrap)
   );

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_unit
      ptg_interval #(
         .IVAL_W (IVAL_W),
         .PER_W  (PER_W)
      ) u_ival (
         .clk       (clk),
         .rst_n     (rst_n),
         .run_i     (running),
         .tick_i    (tick_i),
         .wrap_i    (wrap),
         .ival_i    (interval_i[g*IVAL_W +: IVAL_W]),
         .tick_ns_i (tick_ns_i),
         .pulse_o   (pulse_o[g]),
         .evt_o     (event_o[g])
      );
   end

   // R1: nothing pulses before the first start
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> (event_o == '0));

   initial begin
      if (IVAL_BITS != NUM_GEN * IVAL_W) $error("pulse_train_gen: width mismatch");
   end
endmodule

// File: tb/sim_pulse_train_gen.sv
module sim_pulse_train_gen;
   localparam int CLK_PERIOD = 10;
   localparam int T_NS = 5;

   // {pulse1, pulse0, event1, event0} after running ticks 1..24 (P=4, periods 12 and 8)
   localparam logic [3:0] EXP [24] = '{
      4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hA,
      4'h8, 4'h8, 4'h8, 4'h5, 4'h4, 4'h4, 4'h4, 4'hA,
      4'h8, 4'h8, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        en = 1'b0;
   logic [63:0] tnow = '0;
   logic [63:0] alarm = 64'd1000;
   logic [9:0]  tper = 10'(T_NS);
   logic [15:0] prsc = 16'd4;
   logic [31:0] ival0 = 32'd55;
   logic [31:0] ival1 = 32'd35;
   logic [1:0]  pulse;
   logic [1:0]  evt;

   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_train_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .start_en_i (en),
      .time_i     (tnow),
      .alarm_i    (alarm),
      .tick_ns_i  (tper),
      .prescale_i (prsc),
      .interval_i ({ival1, ival0}),
      .pulse_o    (pulse),
      .event_o    (evt)
   );

   task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick_once();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [3:0] acc;
      @(negedge clk);
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: quiet after reset
      chk({pulse, evt}, 4'h0, "R1");

      // R2: enabled but no match, ticks must not count
      tnow = 64'd995;
      en = 1'b1;
      idle(3);
      acc = '0;
      for (int i = 0; i < 3; i++) begin tick_once(); acc |= {pulse, evt}; end
      chk(acc, 4'h0, "R2 no match");
      tnow = alarm;
      idle(2);
      tnow = 64'd1001;
      idle(1);

      // R4 R5 R7 R8 R10: table of running ticks
      for (int k = 0; k < 24; k++) begin
         tick_once();
         chk({pulse, evt}, EXP[k], $sformatf("R4/R5/R7/R8 tick %0d", k + 1));
         @(negedge clk);
         chk({pulse, evt}, {EXP[k][3:2], 2'b00}, $sformatf("R10 hold after tick %0d", k + 1));
      end

      // R9: drop the enable while both pulses are high
      en = 1'b0;
      idle(2);
      chk({pulse, evt}, 4'h0, "R9 stop");
      acc = '0;
      for (int i = 0; i < 15; i++) begin tick_once(); acc |= {pulse, evt}; end
      chk(acc, 4'h0, "R9 idle ticks");

      // R2: enable again without a match
      en = 1'b1;
      idle(2);
      acc = '0;
      for (int i = 0; i < 15; i++) begin tick_once(); acc |= {pulse, evt}; end
      chk(acc, 4'h0, "R2 rearm needs match");

      // R3: time held at the alarm across all ticks, no restart
      tnow = alarm;
      idle(2);
      for (int k = 1; k <= 12; k++) begin
         tick_once();
         if (k == 8)  chk({pulse, evt}, 4'hA, "R3 unit1 tick 8");
         if (k == 11) chk({pulse, evt}, 4'h8, "R3 tick 11");
         if (k == 12) chk({pulse, evt}, 4'h5, "R3 unit0 tick 12");
      end

      // R6: prescale 0 divides by one; periods 3 and 4 ticks, one-tick pulses
      en = 1'b0;
      idle(3);
      prsc = 16'd0;
      ival0 = 32'd10;
      ival1 = 32'd15;
      en = 1'b1;
      idle(3);
      tick_once(); chk({pulse, evt}, 4'h0, "R6 tick 1");
      tick_once(); chk({pulse, evt}, 4'h0, "R6 tick 2");
      tick_once(); chk({pulse, evt}, 4'h5, "R6 tick 3");
      tick_once(); chk({pulse, evt}, 4'hA, "R6 tick 4");
      tick_once(); chk({pulse, evt}, 4'h0, "R6 tick 5");

      // R1: reset in the middle of a run
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      en = 1'b0;
      idle(1);
      chk({pulse, evt}, 4'h0, "R1 reset again");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule